// File: doc/BRIEF.md
# Bit-Reversed Address Generator

This block produces the write addresses that scatter a buffer of complex samples into bit-reversed order ahead of an in-place radix-2 decimation-in-time FFT. A companion sequential reader fetches sample k while this block supplies the matching scrambled destination address. The FFT's results then appear in natural order. The block issues one address per clock cycle for a programmed number of points. It then pulses a completion flag.

Internally a 14-bit pointer register starts from the bit-reversed image of the base address. On every issued address it advances by a modifier held for the whole run. Every bit of the register is mirrored on the way out, so the modifier sets how many index bits end up reversed. A modifier of 0x0010 gives a 10-bit reversal (1024 points) and 0x0020 gives a 9-bit reversal (512 points). A base whose low reversed bits are zero, such as 0x0000 or 0x1000, is then offset by the reversed sample index. The memories and the data path lie outside the block.

Top module: `bitrev_addr_gen`

## Requirements
- R1: After reset, and before any start, `addr_valid` and `run_done` are both low.
- R2: The first address after an accepted start equals `base_addr` sampled with that start, and it appears in the cycle after the start edge.
- R3: Each later address is the 14-bit mirror image of (the mirror image of the previous address plus the modifier latched at start), with the sum taken modulo 2^14.
- R4: With modifier 0x0010 and a base whose low 10 bits are zero (for example 0x0000 or 0x1000), address k equals base OR the 10-bit reversal of k, for k = 0 to 1023.
- R5: `addr_valid` is high for exactly `point_count` consecutive cycles per run, one address per cycle.
- R6: `run_done` is high for exactly one cycle, the cycle after the last valid address, and is never high together with `addr_valid`.
- R7: A `start` pulse while a run is in progress is ignored. The address sequence and its length are unchanged.
- R8: A start with `point_count` equal to 0 issues no address and raises `run_done` in the cycle after the start edge.
- R9: With modifier 0x0020 and a base whose low 9 bits are zero, address k equals base OR the 9-bit reversal of k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse, accepted only while idle |
| base_addr | input | 14 | First destination address of the run |
| modifier | input | 14 | Pointer increment, latched at start |
| point_count | input | 11 | Number of addresses to issue (0 to 1024) |
| addr_out | output | 14 | Bit-reversed destination address |
| addr_valid | output | 1 | High in each cycle that `addr_out` carries an address |
| run_done | output | 1 | One-cycle pulse after the last address |

## Verification
The hardest point to reach from the ports is the last step of a full 1024-point run. There the pointer register has climbed to 0x3FF0 plus the base image, and the final address must still be followed by exactly one done pulse. The bench therefore sweeps every index of two full 1024-point runs with different aligned bases and a 512-point run at the 9-bit modifier. It also fires a second start partway through a short run to show that the sequence carries on unchanged.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;
  localparam int unsigned ADDR_W  = 14;
  localparam int unsigned MAX_PTS = 1024;
  localparam int unsigned CNT_W   = $clog2(MAX_PTS + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic addr_t mirror(input addr_t v);
    addr_t r;
    for (int i = 0; i < ADDR_W; i++) r[i] = v[ADDR_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/bitrev_mirror.sv
module bitrev_mirror #(
  parameter int unsigned W = 14
) (
  input  logic [W-1:0] in_word,
  output logic [W-1:0] out_word
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_wire
      assign out_word[g] = in_word[W-1-g];
    end
  endgenerate
endmodule

// File: rtl/bitrev_sequencer.sv
module bitrev_sequencer
  import bitrev_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cnt_t point_count,
  output logic load_en,
  output logic step_en,
  output logic busy,
  output logic done
);
  logic busy_q, busy_d;
  logic done_q, done_d;
  cnt_t rem_q, rem_d;

  always_comb begin
    busy_d  = busy_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    step_en = 1'b0;
    if (!busy_q) begin
      if (start) begin
        load_en = 1'b1;
        if (point_count == '0) begin
          done_d = 1'b1;
        end else begin
          busy_d = 1'b1;
          rem_d  = point_count;
        end
      end
    end else begin
      step_en = 1'b1;
      if (rem_q == cnt_t'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        rem_d  = '0;
      end else begin
        rem_d = rem_q - cnt_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      rem_q  <= rem_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_busy_has_work_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0));
endmodule

// File: rtl/bitrev_pointer.sv
module bitrev_pointer
  import bitrev_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  logic  step_en,
  input  addr_t base_addr,
  input  addr_t modifier,
  output addr_t ptr,
  output addr_t mod_held
);
  addr_t ptr_q, ptr_d;
  addr_t mod_q, mod_d;
  logic  ptr_en;

  assign ptr_en = load_en | step_en;

  always_comb begin
    ptr_d = ptr_q;
    mod_d = mod_q;
    if (load_en) begin
      ptr_d = mirror(base_addr);
      mod_d = modifier;
    end else if (step_en) begin
      ptr_d = ptr_q + mod_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      mod_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
      mod_q <= mod_d;
    end
  end

  assign ptr      = ptr_q;
  assign mod_held = mod_q;
endmodule

// File: rtl/bitrev_addr_gen.sv
module bitrev_addr_gen
  import bitrev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] modifier,
  input  logic [CNT_W-1:0]  point_count,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid,
  output logic              run_done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load_en, step_en, busy, done;
  addr_t      ptr, mod_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bitrev_sequencer u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .point_count(point_count),
    .load_en(load_en), .step_en(step_en), .busy(busy), .done(done)
  );

  bitrev_pointer u_ptr (
    .clk(clk), .rst_n(rst_int_n), .load_en(load_en), .step_en(step_en),
    .base_addr(base_addr), .modifier(modifier), .ptr(ptr), .mod_held(mod_held)
  );

  bitrev_mirror #(.W(ADDR_W)) u_mir (.in_word(ptr), .out_word(addr_out));

  assign addr_valid = busy;
  assign run_done   = done;

  assert_first_is_base_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !addr_valid && point_count != '0) |=> (addr_valid && addr_out == $past(base_addr)));
  assert_step_by_mod_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (addr_valid && $past(addr_valid)) |->
      (mirror(addr_out) == addr_t'(mirror($past(addr_out)) + mod_held)));
  assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(run_done && addr_valid));
  assert_restart_ignored_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (addr_valid && start) |=> (addr_valid || run_done));
  assert_empty_run_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !addr_valid && point_count == '0) |=> (run_done && !addr_valid));
endmodule

// File: tb/bitrev_addr_gen_tb.sv
module bitrev_addr_gen_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] base_addr = '0;
  logic [13:0] modifier = '0;
  logic [10:0] point_count = '0;
  logic [13:0] addr_out;
  logic        addr_valid, run_done;

  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  bitrev_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .modifier(modifier), .point_count(point_count), .addr_out(addr_out),
    .addr_valid(addr_valid), .run_done(run_done)
  );

  function automatic int revn(input int v, input int nb);
    int r = 0;
    for (int i = 0; i < nb; i++) if (v[i]) r |= (1 << (nb - 1 - i));
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // cnt addresses expected base | rev_nb(k); optional second start at index glitch
  task automatic run(input string req, input int base, input int modv, input int cnt,
                     input int nb, input int glitch);
    @(negedge clk);
    base_addr = 14'(base); modifier = 14'(modv); point_count = 11'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < cnt; k++) begin
      check({req, " valid"}, int'(addr_valid), 1);
      check({req, " addr"}, int'(addr_out), base | revn(k, nb));
      check({req, " R6 no done mid-run"}, int'(run_done), 0);
      if (k == glitch) begin
        base_addr = 14'h2000; modifier = 14'h0001; point_count = 11'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check({req, " R5 valid drops"}, int'(addr_valid), 0);
    check({req, " R6 done pulse"}, int'(run_done), 1);
    @(negedge clk);
    check({req, " R6 done single"}, int'(run_done), 0);
    check({req, " R5 idle"}, int'(addr_valid), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    check("R1 valid", int'(addr_valid), 0);
    check("R1 done", int'(run_done), 0);

    // R4/R2/R3: full 1024-point sweep, base 0 and base 0x1000
    run("R4 base0", 0, 16, 1024, 10, -1);
    run("R4 R2 base1000", 'h1000, 16, 1024, 10, -1);
    // R9: 9-bit reversal
    run("R9 R3", 0, 32, 512, 9, -1);
    // R7: start during run ignored
    run("R7", 0, 16, 8, 10, 3);
    // single address
    run("R2 R5 one", 'h1000, 16, 1, 10, -1);

    // R8: zero count
    @(negedge clk);
    base_addr = '0; modifier = 14'h10; point_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 done", int'(run_done), 1);
    check("R8 valid", int'(addr_valid), 0);
    @(negedge clk);
    check("R8 done clears", int'(run_done), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule